// File: doc/BRIEF.md
# Single-Slope Fast PWM Timer

An 8-bit up-counter driven by a selectable clock divider. On each divided tick it counts up from zero to a TOP value, then returns to zero on the following tick. Two compare channels watch the count. Each channel drives one waveform pin, in a mode picked by a 2-bit field. The pin can be held, toggled (channel A only), driven as non-inverted PWM, or driven as inverted PWM. TOP is either the full count of 255 or the active channel A compare value. This makes the PWM frequency either fixed or tunable.

Software writes new compare values into buffer registers. The buffers move into the active compare registers only on the tick where the counter is at TOP, so a period never mixes two duty settings. Three sticky flags mark reaching TOP and each channel's compare match. Writing a 1 to a flag's bit clears that flag.

Top module: `fast_pwm_timer`

## Requirements
- R1: A write strobes `wr_data` into the register chosen by `wr_addr` on a rising clock edge. Address 0 is control: bits [2:0] divider select, bit 3 TOP-from-A, bits [5:4] channel A mode, bits [7:6] channel B mode. Address 1 is the channel A compare buffer, address 2 the channel B compare buffer, and address 3 the flag clear (bit 0 overflow, bit 1 compare A, bit 2 compare B).
- R2: After reset, both waveform pins, all flags, the counter, the control register and both compare registers are zero.
- R3: Divider select codes 1, 2, 3, 4 and 5 give one counter tick every 1, 8, 64, 256 or 1024 clocks. The counter rises by one per tick and goes from TOP to zero on the next tick. After a control write with a new select, the first overflow at TOP=255 comes exactly 256×N clocks after the write edge.
- R4: Select codes 0, 6 and 7 stop the counter: no tick occurs, so no flag sets and no pin changes.
- R5: With control bit 3 clear, TOP is 255. With it set, TOP is the active channel A compare value.
- R6: The overflow flag sets on the tick where the counter equals TOP.
- R7: A channel's compare flag sets on the tick where the counter equals that channel's active compare value.
- R8: Writing address 3 clears each flag whose data bit is 1 and leaves the others. A set in the same cycle wins over a clear.
- R9: Mode 2 (non-inverted) sets the pin on the TOP tick and clears it on a compare-match tick. The pin is high for min(OCR, TOP)+1 ticks of every TOP+1, so a compare value of 0 gives a one-tick spike.
- R10: Mode 3 (inverted) clears the pin on the TOP tick and sets it on a compare-match tick. The pin is low for min(OCR, TOP)+1 ticks of every TOP+1.
- R11: Mode 1 toggles pin A on each channel A match only while control bit 3 is set. Otherwise, and always on channel B, mode 1 holds the pin.
- R12: Mode 0 holds the pin at its last value.
- R13: Compare buffers load into the active compare registers only on the TOP tick. A buffer write during a period leaves that period's waveform unchanged.
- R14: A control write whose select differs from the current one clears the divider count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| oc_a | output | 1 | Channel A waveform |
| oc_b | output | 1 | Channel B waveform |
| flag_ovf | output | 1 | Sticky TOP-reached flag |
| flag_cmp_a | output | 1 | Sticky channel A match flag |
| flag_cmp_b | output | 1 | Sticky channel B match flag |

## Verification
A wrong divider or counter state shows up as a shift in when the overflow flag sets. The bench therefore measures exact clock distances between overflow events and control writes, which catches an off-by-one within one period. A corrupt active compare value or a misplaced buffer load changes how many clocks a pin stays high within the period after the load, so duty is counted over whole periods. Flag logic faults appear on the very next cycle after a clear write.

// File: rtl/fast_pwm_timer.sv
module fast_pwm_timer #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 10
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [1:0]                           wr_addr,
  input  logic [((CNT_W < 8) ? 8 : CNT_W)-1:0] wr_data,
  output logic                                 oc_a,
  output logic                                 oc_b,
  output logic                                 flag_ovf,
  output logic                                 flag_cmp_a,
  output logic                                 flag_cmp_b
);
  localparam int DW = (CNT_W < 8) ? 8 : CNT_W;
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [7:0]       ctrl_q;
  logic [CNT_W-1:0] cnt_q, buf_a_q, buf_b_q, act_a_q, act_b_q;
  logic [PRE_W-1:0] pre_q, div_m1;
  logic [2:0]       sel;
  logic             top_a, running, tick, at_top, hit_a, hit_b;
  logic [1:0]       mode_a, mode_b;
  logic [CNT_W-1:0] top;

  wire wr_ctrl = wr_en && wr_addr == 2'd0;
  wire wr_clr  = wr_en && wr_addr == 2'd3;

  assign sel    = ctrl_q[2:0];
  assign top_a  = ctrl_q[3];
  assign mode_a = ctrl_q[5:4];
  assign mode_b = ctrl_q[7:6];
  assign top    = top_a ? act_a_q : MAXV;

  always_comb begin
    running = 1'b1;
    case (sel)
      3'd1:    div_m1 = PRE_W'(0);
      3'd2:    div_m1 = PRE_W'(7);
      3'd3:    div_m1 = PRE_W'(63);
      3'd4:    div_m1 = PRE_W'(255);
      3'd5:    div_m1 = PRE_W'(1023);
      default: begin div_m1 = '0; running = 1'b0; end
    endcase
  end

  assign tick   = running && pre_q == div_m1;
  assign at_top = cnt_q == top;
  assign hit_a  = cnt_q == act_a_q;
  assign hit_b  = cnt_q == act_b_q;

  function automatic logic pwm_next(input logic [1:0] mode, input logic tog_ok,
                                    input logic hit_top, input logic hit, input logic cur);
    case (mode)
      2'd1:    return (tog_ok && hit) ? ~cur : cur;
      2'd2:    return hit_top ? 1'b1 : (hit ? 1'b0 : cur);
      2'd3:    return hit_top ? 1'b0 : (hit ? 1'b1 : cur);
      default: return cur;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      buf_a_q <= '0;
      buf_b_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == 2'd0) ctrl_q  <= wr_data[7:0];
      if (wr_addr == 2'd1) buf_a_q <= wr_data[CNT_W-1:0];
      if (wr_addr == 2'd2) buf_b_q <= wr_data[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              pre_q <= '0;
    else if (wr_ctrl && wr_data[2:0] != sel) pre_q <= '0;
    else if (!running || tick)               pre_q <= '0;
    else                                     pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      act_a_q <= '0;
      act_b_q <= '0;
      oc_a    <= 1'b0;
      oc_b    <= 1'b0;
    end else if (tick) begin
      cnt_q <= at_top ? '0 : cnt_q + 1'b1;
      if (at_top) begin
        act_a_q <= buf_a_q;
        act_b_q <= buf_b_q;
      end
      oc_a <= pwm_next(mode_a, top_a, at_top, hit_a, oc_a);
      oc_b <= pwm_next(mode_b, 1'b0,  at_top, hit_b, oc_b);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_ovf   <= 1'b0;
      flag_cmp_a <= 1'b0;
      flag_cmp_b <= 1'b0;
    end else begin
      flag_ovf   <= (tick && at_top) || (flag_ovf   && !(wr_clr && wr_data[0]));
      flag_cmp_a <= (tick && hit_a)  || (flag_cmp_a && !(wr_clr && wr_data[1]));
      flag_cmp_b <= (tick && hit_b)  || (flag_cmp_b && !(wr_clr && wr_data[2]));
    end
  end

  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    tick && at_top |=> cnt_q == '0);
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !at_top |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> $stable(cnt_q) && $stable(oc_a) && $stable(oc_b));
  a_r6_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    tick && at_top |=> flag_ovf);
  a_r8_clr_a: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr && wr_data[1] && !(tick && hit_a) |=> !flag_cmp_a);
  a_r9_set_top: assert property (@(posedge clk) disable iff (!rst_n)
    tick && at_top && mode_a == 2'd2 |=> oc_a);
  a_r10_clr_top: assert property (@(posedge clk) disable iff (!rst_n)
    tick && at_top && mode_a == 2'd3 |=> !oc_a);
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mode_a == 2'd0 |=> $stable(oc_a));
  a_r13_load: assert property (@(posedge clk) disable iff (!rst_n)
    tick && at_top |=> act_a_q == $past(buf_a_q) && act_b_q == $past(buf_b_q));
  a_r13_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && at_top) |=> $stable(act_a_q) && $stable(act_b_q));
  a_r14_pre_clr: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && wr_data[2:0] != sel |=> pre_q == '0);
endmodule

// File: tb/sim_fast_pwm_timer.sv
module sim_fast_pwm_timer;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic oc_a, oc_b, flag_ovf, flag_cmp_a, flag_cmp_b;
  int n_chk = 0, n_bad = 0, cyc = 0;

  fast_pwm_timer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .oc_a(oc_a), .oc_b(oc_b), .flag_ovf(flag_ovf),
    .flag_cmp_a(flag_cmp_a), .flag_cmp_b(flag_cmp_b));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // {ctrl, cmp A, cmp B, A high clocks over two periods, B high clocks over two periods}
  localparam logic [55:0] VEC [7] = '{
    {8'hE1, 8'd100, 8'd50,  16'd202, 16'd410},  // R9 R10
    {8'hA1, 8'd0,   8'd255, 16'd2,   16'd512},  // R9 spike and full
    {8'h31, 8'd0,   8'd10,  16'd510, 16'd0},    // R10 R12
    {8'h99, 8'd99,  8'd40,  16'd100, 16'd82},   // R5 R11 toggle
    {8'hA9, 8'd49,  8'd200, 16'd100, 16'd100},  // R5 compare above TOP
    {8'h51, 8'd30,  8'd30,  16'd0,   16'd0},    // R11 no toggle
    {8'hF1, 8'd255, 8'd127, 16'd0,   16'd256}   // R10
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_ovf(output int c);
    while (!flag_ovf) @(negedge clk);
    c = cyc;
  endtask

  initial begin
    int c0, c1, c2, ha, hb, seen;
    do_reset();
    chk("R2 reset outputs", {oc_a, oc_b, flag_ovf, flag_cmp_a, flag_cmp_b}, 0);

    for (int i = 0; i < 7; i++) begin
      int t;
      do_reset();
      wr(2'd1, VEC[i][47:40]);
      wr(2'd2, VEC[i][39:32]);
      wr(2'd0, VEC[i][55:48]);
      repeat (600) @(negedge clk);
      t = VEC[i][51] ? int'(VEC[i][47:40]) : 255;
      ha = 0; hb = 0;
      for (int k = 0; k < 2 * (t + 1); k++) begin
        @(negedge clk);
        ha += oc_a; hb += oc_b;
      end
      chk($sformatf("R1 R9 R10 R11 R12 vector %0d pin A", i), ha, int'(VEC[i][31:16]));
      chk($sformatf("R1 R9 R10 R11 R12 vector %0d pin B", i), hb, int'(VEC[i][15:0]));
    end

    // R7: match at count 0 one tick after the start
    do_reset();
    wr(2'd0, 8'h01);
    chk("R7 no match before first tick", flag_cmp_a, 0);
    @(negedge clk);
    chk("R7 match flag on first tick", flag_cmp_a, 1);

    // R3 R14: divider cleared by the select change
    do_reset();
    wr(2'd0, 8'h03);
    repeat (5) @(negedge clk);
    wr(2'd0, 8'h02); c0 = cyc;
    wait_ovf(c1);
    chk("R3 R14 /8 first overflow", c1 - c0, 2048);
    wr(2'd3, 8'h01);
    wait_ovf(c2);
    chk("R3 R6 /8 overflow spacing", c2 - c1, 2048);

    do_reset();
    wr(2'd0, 8'h03); c0 = cyc;
    wait_ovf(c1);
    chk("R3 /64 first overflow", c1 - c0, 16384);

    do_reset();
    wr(2'd0, 8'h01); c0 = cyc;
    wait_ovf(c1);
    chk("R3 R6 /1 first overflow", c1 - c0, 256);

    // R4: stopped counter sets no flag
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h07);
    seen = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      seen += flag_ovf + flag_cmp_a + flag_cmp_b;
    end
    chk("R4 stopped flags", seen, 0);

    // R8: selective clear
    do_reset();
    wr(2'd1, 8'd10); wr(2'd2, 8'd20); wr(2'd0, 8'h01);
    repeat (600) @(negedge clk);
    wr(2'd0, 8'h00);
    chk("R8 all flags set", {flag_ovf, flag_cmp_a, flag_cmp_b}, 3'b111);
    wr(2'd3, 8'h02);
    chk("R8 clear only A", {flag_ovf, flag_cmp_a, flag_cmp_b}, 3'b101);
    wr(2'd3, 8'h05);
    chk("R8 clear rest", {flag_ovf, flag_cmp_a, flag_cmp_b}, 3'b000);

    // R13: buffer write mid-period takes effect at next TOP
    do_reset();
    wr(2'd1, 8'd200); wr(2'd0, 8'h21);
    repeat (600) @(negedge clk);
    wr(2'd3, 8'h01);
    wait_ovf(c1);
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'd20;
    ha = 0; hb = 0;
    for (int k = 0; k < 512; k++) begin
      if (k < 256) ha += oc_a; else hb += oc_a;
      @(negedge clk);
      wr_en = 1'b0;
    end
    chk("R13 old duty kept this period", ha, 201);
    chk("R13 new duty next period", hb, 21);

    // R12: mode 0 holds a high pin
    wr(2'd3, 8'h01);
    wait_ovf(c1);
    wr(2'd0, 8'h01);
    seen = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      seen += !oc_a;
    end
    chk("R12 pin held high", seen, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL all watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule